// File: doc/BRIEF.md
# Double-Indirection Lookup Engine

This block is a small register-mapped accelerator that follows a pointer to a pointer. A host loads two 32-bit operands. The engine adds them to form a memory address and reads the word stored there. It then uses that word as a second address and reads again. The word from the second read lands in a result register, where the host can read it.

The host side is a plain word-offset register window: one write strobe, a two-bit word index, write data, and combinational read data. The memory side is a single synchronous read port with one cycle of latency. Both reads share that port, so a sequencer issues them one after the other, with a wait cycle after each. A status word shows whether a lookup is in flight and whether one has finished.

Writing the second operand starts a lookup. The address adder wraps modulo 2^32, and only the low `ADDR_W` bits of each address reach the memory port.

Top module: `ptr_chase_engine`

## Requirements
- R1: After a synchronous active-high reset, words 0 to 3 of the register window all read as zero and the memory read strobe is low.
- R2: Word 0 holds operand A and word 1 holds operand B. Both can be written while the engine is not busy and read back unchanged.
- R3: A write to word 1 while not busy starts a lookup. From the next cycle, the status word (word 3) reads busy in bit 0 set and done in bit 1 clear, that is, 0x1.
- R4: The first memory read uses the low `ADDR_W` bits of A + B, computed modulo 2^32, so a sum that overflows 32 bits wraps around.
- R5: The second memory read uses the low `ADDR_W` bits of the word returned by the first read.
- R6: The word returned by the second read appears at word 2. In the same cycle, done is set and busy clears, so status reads 0x2 four cycles after the starting write.
- R7: Writes to the operand words while busy are ignored. The operands keep their values and no second lookup starts.
- R8: The result word keeps its previous value until the second read returns.
- R9: Writes to word 2 or word 3 have no effect on the result, the status or the memory port.
- R10: Each lookup issues exactly two one-cycle read strobes, and a strobe is never high two cycles in a row.
- R11: The done bit stays set until the next lookup starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_word | input | 2 | Word index: 0 operand A, 1 operand B, 2 result, 3 status |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data for the selected word, combinational |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after the strobe |

## Verification
A sequencer that skips a state or stalls shows up at the memory strobe within one cycle: two strobes in a row, too few strobes, or no strobe at all. It also shows up at the status word, which is 0x2 exactly four cycles after a start. A pointer latched in the wrong cycle, or a wrong adder width, sends the second strobe to the wrong address. That wrong address returns a result that differs from the two-level memory model, and the result word shows it on the cycle done rises. An operand register that accepts writes while busy is caught at the next readback of words 0 and 1. It also shows as extra read strobes in the strobe count.

// File: rtl/pce_pkg.sv
package pce_pkg;

   // Sequencer states
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD1  = 3'd1,
      ST_WT1  = 3'd2,
      ST_RD2  = 3'd3,
      ST_WT2  = 3'd4,
      ST_DONE = 3'd5
   } pce_state_t;

   // Register window word indices
   localparam logic [1:0] W_OPA  = 2'd0;
   localparam logic [1:0] W_OPB  = 2'd1;
   localparam logic [1:0] W_RES  = 2'd2;
   localparam logic [1:0] W_STAT = 2'd3;

   // Status bit positions
   localparam int STAT_BUSY = 0;
   localparam int STAT_DONE = 1;

endpackage

// File: rtl/pce_addr_gen.sv
module pce_addr_gen #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 10
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [ADDR_W-1:0] ptr,
   input  logic              use_ptr,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] sum_lo;

   generate
      if (ADDR_W == DATA_W) begin : g_full
         // Full-width add, natural wrap
         assign sum_lo = opa + opb;
      end else begin : g_narrow
         // Only low bits matter modulo 2^ADDR_W
         logic [DATA_W-1:0] sum_full;
         assign sum_full = opa + opb;
         assign sum_lo   = sum_full[ADDR_W-1:0];
      end
   endgenerate

   assign addr = use_ptr ? ptr : sum_lo;

endmodule

// File: rtl/pce_seq.sv
module pce_seq
   import pce_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic busy,
   output logic rd_en,
   output logic use_ptr,
   output logic cap_ptr,
   output logic cap_res
);
   pce_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (start) st_d = ST_RD1;
         ST_RD1:  st_d = ST_WT1;
         ST_WT1:  st_d = ST_RD2;
         ST_RD2:  st_d = ST_WT2;
         ST_WT2:  st_d = ST_DONE;
         ST_DONE: st_d = start ? ST_RD1 : ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_d;
   end

   assign busy    = (st_q == ST_RD1) || (st_q == ST_WT1) ||
                    (st_q == ST_RD2) || (st_q == ST_WT2);
   assign rd_en   = (st_q == ST_RD1) || (st_q == ST_RD2);
   assign use_ptr = (st_q == ST_RD2);
   assign cap_ptr = (st_q == ST_WT1);
   assign cap_res = (st_q == ST_WT2);

endmodule

// File: rtl/ptr_chase_engine.sv
module ptr_chase_engine
   import pce_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_wr,
   input  logic [1:0]        host_word,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int STAT_BITS = 2;

   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr
         $error("ptr_chase_engine: ADDR_W must lie in 1..DATA_W");
      end
      if (DATA_W < STAT_BITS) begin : g_bad_data
         $error("ptr_chase_engine: DATA_W too small for status word");
      end
   endgenerate

   logic              busy, use_ptr, cap_ptr, cap_res, start;
   logic [DATA_W-1:0] opa, opb, result;
   logic [ADDR_W-1:0] ptr;
   logic              done_q;
   logic              wr_ok;

   assign wr_ok = host_wr && !busy;
   assign start = wr_ok && (host_word == W_OPB);

   pce_seq u_seq (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .busy    (busy),
      .rd_en   (mem_rd_en),
      .use_ptr (use_ptr),
      .cap_ptr (cap_ptr),
      .cap_res (cap_res)
   );

   pce_addr_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_agen (
      .opa     (opa),
      .opb     (opb),
      .ptr     (ptr),
      .use_ptr (use_ptr),
      .addr    (mem_addr)
   );

   // Operand registers
   always_ff @(posedge clk) begin
      if (rst) begin
         opa <= '0;
         opb <= '0;
      end else if (wr_ok) begin
         if (host_word == W_OPA) opa <= host_wdata;
         if (host_word == W_OPB) opb <= host_wdata;
      end
   end

   // Pointer, result and sticky done flag
   always_ff @(posedge clk) begin
      if (rst) begin
         ptr    <= '0;
         result <= '0;
         done_q <= 1'b0;
      end else begin
         if (cap_ptr) ptr <= mem_rdata[ADDR_W-1:0];
         if (cap_res) result <= mem_rdata;
         if (start)        done_q <= 1'b0;
         else if (cap_res) done_q <= 1'b1;
      end
   end

   // Read mux
   logic [DATA_W-1:0] stat_word;
   always_comb begin
      stat_word            = '0;
      stat_word[STAT_BUSY] = busy;
      stat_word[STAT_DONE] = done_q;
   end

   always_comb begin
      unique case (host_word)
         W_OPA:   host_rdata = opa;
         W_OPB:   host_rdata = opb;
         W_RES:   host_rdata = result;
         default: host_rdata = stat_word;
      endcase
   end

endmodule

// File: rtl/pce_chk.sv
module pce_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              host_wr,
   input logic [1:0]        host_word,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              busy,
   input logic              done_q,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [DATA_W-1:0] result
);
   logic [DATA_W-1:0] sum_chk;
   assign sum_chk = opa + opb;

   // R10
   rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
      mem_rd_en |=> !mem_rd_en);

   // R3
   start_chk: assert property (@(posedge clk) disable iff (rst)
      (host_wr && host_word == 2'd1 && !busy) |=> (busy && !done_q));

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (host_wr && busy) |=> ($stable(opa) && $stable(opb)));

   // R8
   res_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(result) |-> $rose(done_q));

   // R6
   finish_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> done_q);

   // R4
   first_addr_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> (mem_rd_en && mem_addr == sum_chk[ADDR_W-1:0]));

endmodule

bind ptr_chase_engine pce_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .host_wr   (host_wr),
   .host_word (host_word),
   .mem_rd_en (mem_rd_en),
   .mem_addr  (mem_addr),
   .busy      (busy),
   .done_q    (done_q),
   .opa       (opa),
   .opb       (opb),
   .result    (result)
);

// File: tb/sim_ptr_chase_engine.sv
`timescale 1ns/1ps
module sim_ptr_chase_engine;
   localparam int DW = 32;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          host_wr = 1'b0;
   logic [1:0]    host_word = 2'd0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic          mem_rd_en;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata = '0;

   always #2.5 clk = ~clk;

   ptr_chase_engine #(.DATA_W(DW), .ADDR_W(AW)) u0 (
      .clk(clk), .rst(rst), .host_wr(host_wr), .host_word(host_word),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
   );

   // Synchronous RAM model, one cycle latency
   logic [DW-1:0] ram [0:(1<<AW)-1];
   always @(posedge clk) if (mem_rd_en) mem_rdata <= ram[mem_addr];

   int errs = 0;
   int checks = 0;
   int pulses = 0;
   int cd = 0;
   int lookups = 0;
   bit run_done = 1'b0;
   logic [DW-1:0] expq[$];
   logic [DW-1:0] prev_res = '0;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] w, output logic [DW-1:0] v);
      host_word = w;
      #1 v = host_rdata;
   endtask

   function automatic logic [DW-1:0] model(input logic [DW-1:0] a, input logic [DW-1:0] b);
      logic [DW-1:0] s;
      logic [DW-1:0] p;
      s = a + b;
      p = ram[s[AW-1:0]];
      return ram[p[AW-1:0]];
   endfunction

   // Monitor: result is due two edges after the second strobe (R5, R6)
   always @(negedge clk) begin
      if (!rst) begin
         if (cd != 0) begin
            cd--;
            if (cd == 0) begin
               if (expq.size() == 0) begin
                  checks++; errs++;
                  $display("FAIL R6 actual=%h expected=<none queued>", host_rdata);
               end else begin
                  chk("R5/R6 result", host_rdata, expq.pop_front());
               end
            end
         end
         if (mem_rd_en) begin
            pulses++;
            if (pulses % 2 == 0) cd = 2;
         end
      end
   end

   // Driver: one lookup, optionally with writes attempted while busy
   task automatic lookup(input logic [DW-1:0] a, input logic [DW-1:0] b, input bit inject);
      logic [DW-1:0] v;
      logic [DW-1:0] e;
      e = model(a, b);
      @(negedge clk); host_wr = 1'b1; host_word = 2'd0; host_wdata = a;
      @(negedge clk); host_word = 2'd1; host_wdata = b;
      expq.push_back(e);
      lookups++;
      @(negedge clk); host_wr = 1'b0;
      rd(2'd3, v); chk("R3 busy status", v, 32'h1);
      if (inject) begin
         @(negedge clk); host_wr = 1'b1; host_word = 2'd0; host_wdata = 32'h0BAD_0BAD;
         @(negedge clk); host_word = 2'd1; host_wdata = 32'h0000_0777;
         @(negedge clk); host_wr = 1'b0;
         rd(2'd2, v); chk("R8 result held", v, prev_res);
         repeat (2) @(negedge clk);
      end else begin
         @(negedge clk);
         rd(2'd2, v); chk("R8 result held", v, prev_res);
         repeat (4) @(negedge clk);
      end
      rd(2'd3, v); chk("R6 done status", v, 32'h2);
      rd(2'd0, v); chk("R2/R7 operand A", v, a);
      rd(2'd1, v); chk("R2/R7 operand B", v, b);
      rd(2'd2, v); chk("R6 result word", v, e);
      chk("R10 strobe count", pulses, 2 * lookups);
      prev_res = e;
   endtask

   initial begin
      logic [DW-1:0] v;
      for (int i = 0; i < (1 << AW); i++) ram[i] = (i * 32'h0001_0003) ^ 32'h5A00_0000;
      ram[10'h3CD] = 32'h0000_0100;
      ram[10'h100] = 32'h0000_0005;
      ram[10'h001] = 32'hFFFF_F802;
      ram[10'h002] = 32'hCAFE_0002;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      rd(2'd0, v); chk("R1 opA reset", v, 32'h0);
      rd(2'd1, v); chk("R1 opB reset", v, 32'h0);
      rd(2'd2, v); chk("R1 result reset", v, 32'h0);
      rd(2'd3, v); chk("R1 status reset", v, 32'h0);
      chk("R1 strobe low", {31'b0, mem_rd_en}, 32'h0);

      // Main example: sum 0xABCD, RAM indexes with the low 10 bits
      lookup(32'h0000_000D, 32'h0000_ABC0, 1'b0);
      chk("R4/R5 example value", prev_res, 32'h5);

      // R4 wrap: 0xFFFFFFFF + 2 = 1
      lookup(32'hFFFF_FFFF, 32'h0000_0002, 1'b0);
      chk("R4 wrapped sum value", prev_res, 32'hCAFE_0002);

      // R7 writes during busy ignored
      lookup(32'h0000_1234, 32'h0000_0100, 1'b1);

      // R11 done sticky over idle cycles
      repeat (6) @(negedge clk);
      rd(2'd3, v); chk("R11 done sticky", v, 32'h2);

      // R9 writes to result and status words ignored
      @(negedge clk); host_wr = 1'b1; host_word = 2'd2; host_wdata = 32'hDEAD_BEEF;
      @(negedge clk); host_word = 2'd3; host_wdata = 32'hFFFF_FFFF;
      @(negedge clk); host_wr = 1'b0;
      rd(2'd2, v); chk("R9 result unchanged", v, prev_res);
      rd(2'd3, v); chk("R9 status unchanged", v, 32'h2);
      chk("R9 no strobes", pulses, 2 * lookups);

      // Sum of all ones, top of the RAM
      lookup(32'h7FFF_FFFF, 32'h8000_0000, 1'b0);

      repeat (4) @(negedge clk);
      chk("R10 final strobe count", pulses, 2 * lookups);
      chk("R6 queue drained", expq.size(), 0);
      run_done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!run_done) begin
         checks++; errs++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule